// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Selectable Nesting

The block gathers up to eight interrupt request lines and presents one of them at a time to a processor. Each line is captured on its rising edge into a pending set. The controller then offers the highest-priority line that is allowed to interrupt, and line 7 always wins over lower indices. The processor takes the offered line with an acknowledge pulse at an instruction boundary. When no line is offered, an acknowledge does nothing, and the processor simply carries on fetching.

A policy input selects how a request that arrives during service is treated. In serial policy, nothing is offered while any handler runs, so requests that arrive then are handled one after another. In preemptive policy, only a line strictly above the current service level can break in. When that handler signals end of service, the interrupted lower level becomes current again. A per-line mask input hides lines from the offer but keeps their pending state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_ni is low and right after it is released, irq_o is 0 and no line is pending or in service.
- R2: A line becomes pending at the clock edge where it is seen high after being low. A line held high does not become pending again after it has been taken; it must fall and rise again.
- R3: irq_o is 1 exactly when at least one pending, unmasked, eligible line exists. vec_o is then the 3-bit index of the highest such line, with index 7 the highest priority.
- R4: An ack_i pulse while irq_o is 1 clears the pending bit of line vec_o and puts that line in service at the same edge. An ack_i while irq_o is 0 changes nothing.
- R5: With nest_en_i = 0 (serial policy), irq_o stays 0 while any line is in service.
- R6: Requests raised during service stay pending and are offered in priority order once service ends.
- R7: With nest_en_i = 1 (preemptive policy), a pending line whose index is strictly greater than the current service level is offered.
- R8: With nest_en_i = 1, a pending line at or below the current service level is not offered.
- R9: An eos_i pulse removes the highest level in service, and the next lower in-service level becomes current again.
- R10: mask_i[i] = 1 keeps line i from being offered without clearing its pending bit. When the mask bit is cleared, the line is offered again.
- R11: If ack_i (with irq_o = 1) and eos_i are given in the same cycle, the current level leaves service and the offered line enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request lines, captured on their rising edges |
| mask_i | input | 8 | Per-line offer mask, 1 = hidden |
| nest_en_i | input | 1 | Policy: 0 = serial, 1 = preemptive |
| ack_i | input | 1 | Processor acknowledge at an instruction boundary |
| eos_i | input | 1 | End of service for the current level |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Index of the offered line, valid while irq_o is 1 |

## Verification
A request rise driven between edges sets its pending bit at the next rising edge. irq_o and vec_o reflect it immediately after that same edge, because the offer logic is combinational from the registers, mask_i and nest_en_i. An acknowledge or end-of-service pulse changes the service state at the edge where it is sampled, so the new offer is visible right after that edge. The bench therefore drives inputs just after a falling edge and updates its stack-based model on each rising edge. It compares irq_o and vec_o at the following falling edge, exactly one edge after each stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    POL_SERIAL = 1'b0,
    POL_PREEMPT = 1'b1
  } irq_policy_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_LINES = 8,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  // ascending scan: the last hit is the highest index
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] req_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      // a fresh edge wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_insvc.sv
module irq_insvc #(
  parameter int N_LINES = 8,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic               pop_i,
  output logic [N_LINES-1:0] isr_o,
  output logic               busy_o,
  output logic [IDX_W-1:0]   lvl_o
);
  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] isr_d;

  irq_prio_enc #(.N_LINES(N_LINES)) u_lvl_enc (
    .vec_i (isr_q),
    .any_o (busy_o),
    .idx_o (lvl_o)
  );

  // pop the current level first, then push the granted one
  always_comb begin
    isr_d = isr_q;
    if (pop_i && busy_o) isr_d[lvl_o] = 1'b0;
    if (set_i) isr_d[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_LINES = 8,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               nest_en_i,
  input  logic               ack_i,
  input  logic               eos_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   vec_o
);
  import irq_pkg::*;

  irq_policy_e        policy;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] isr;
  logic [N_LINES-1:0] clr;
  logic [N_LINES-1:0] above;
  logic [N_LINES-1:0] elig;
  logic               busy;
  logic [IDX_W-1:0]   lvl;
  logic               grant;

  assign policy = irq_policy_e'(nest_en_i);

  irq_edge_pend #(.N_LINES(N_LINES)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_insvc #(.N_LINES(N_LINES)) u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (grant),
    .set_idx_i (vec_o),
    .pop_i     (eos_i),
    .isr_o     (isr),
    .busy_o    (busy),
    .lvl_o     (lvl)
  );

  // per-line eligibility against the service level and policy
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign above[g] = !busy || ((policy == POL_PREEMPT) && (IDX_W'(g) > lvl));
    assign clr[g]   = grant && (vec_o == IDX_W'(g));
  end

  assign elig = pend & ~mask_i & above;

  irq_prio_enc #(.N_LINES(N_LINES)) u_req_enc (
    .vec_i (elig),
    .any_o (irq_o),
    .idx_o (vec_o)
  );

  assign grant = ack_i && irq_o;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_LINES = 8,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] mask_i,
  input logic               nest_en_i,
  input logic               ack_i,
  input logic               eos_i,
  input logic               irq_o,
  input logic [IDX_W-1:0]   vec_o,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] isr
);
  assert_offer_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend[vec_o]);

  assert_mask_hides_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mask_i[vec_o]);

  assert_serial_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nest_en_i && (isr != '0)) |-> !irq_o);

  assert_preempt_above_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((isr >> vec_o) == '0));

  assert_grant_enters_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> isr[$past(vec_o)]);

  assert_no_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && irq_o) |=> ((isr & ~$past(isr)) == '0));

  assert_eos_pops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !ack_i && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mask_i    (mask_i),
  .nest_en_i (nest_en_i),
  .ack_i     (ack_i),
  .eos_i     (eos_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .pend      (pend),
  .isr       (isr)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] req = '0;
  logic [7:0] mask = '0;
  logic       nest = 0;
  logic       ack = 0;
  logic       eos = 0;
  logic       irq;
  logic [2:0] vec;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural model
  bit mpend[8];
  bit rprev[8];
  int stk[$];

  always #4 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mask_i(mask),
    .nest_en_i(nest), .ack_i(ack), .eos_i(eos), .irq_o(irq), .vec_o(vec)
  );

  function automatic int model_vec();
    int v = -1;
    for (int i = 0; i < 8; i++) begin
      if (mpend[i] && !mask[i] &&
          (stk.size() == 0 || (nest && i > stk[stk.size()-1])))
        v = i;
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin mpend[i] = 0; rprev[i] = 0; end
      stk.delete();
    end else begin
      int v;
      v = model_vec();
      if (eos && stk.size() > 0) void'(stk.pop_back());
      if (ack && v >= 0) begin
        mpend[v] = 0;
        stk.push_back(v);
      end
      for (int i = 0; i < 8; i++) begin
        if (req[i] && !rprev[i]) mpend[i] = 1;
        rprev[i] = req[i];
      end
    end
  end

  task automatic cmp(bit ei, int ev, string t);
    checks++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL %s: irq_o actual %0b expected %0b", t, irq, ei);
    end else if (ei && vec !== ev[2:0]) begin
      fails++;
      $display("FAIL %s: vec_o actual %0d expected %0d", t, vec, ev);
    end
  endtask

  // one clock, then compare against the model at the falling edge
  task automatic tick();
    int v;
    @(posedge clk);
    @(negedge clk);
    v = model_vec();
    cmp(v >= 0, v, tag);
  endtask

  task automatic expect_port(bit ei, int ev, string t);
    cmp(ei, ev, t);
  endtask

  task automatic do_ack(); ack = 1; tick(); ack = 0; endtask
  task automatic do_eos(); eos = 1; tick(); eos = 0; endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    tick(); tick();
    expect_port(0, 0, "R1");
    rst_n = 1;
    tick();
    expect_port(0, 0, "R1");

    // serial policy
    tag = "R3";
    req[3] = 1; tick(); expect_port(1, 3, "R3");
    req[5] = 1; tick(); expect_port(1, 5, "R3");
    tag = "R5";
    do_ack(); expect_port(0, 0, "R5");
    req[7] = 1; tick(); expect_port(0, 0, "R5");
    tag = "R6";
    do_eos(); expect_port(1, 7, "R6");
    do_ack(); expect_port(0, 0, "R6");
    do_eos(); expect_port(1, 3, "R6");
    do_ack(); do_eos();
    tag = "R2";
    tick(); expect_port(0, 0, "R2");
    req = '0; tick();
    req[3] = 1; tick(); expect_port(1, 3, "R2");
    do_ack(); do_eos(); req = '0; tick();

    tag = "R4";
    do_ack(); expect_port(0, 0, "R4");
    req[4] = 1; tick(); expect_port(1, 4, "R4");
    do_ack(); expect_port(0, 0, "R4");
    do_eos(); req = '0; tick();

    // preemptive policy
    nest = 1;
    tag = "R8";
    req[2] = 1; tick(); do_ack();
    req[1] = 1; tick(); expect_port(0, 0, "R8");
    req[2] = 0; tick(); req[2] = 1; tick(); expect_port(0, 0, "R8");
    tag = "R7";
    req[6] = 1; tick(); expect_port(1, 6, "R7");
    do_ack(); expect_port(0, 0, "R7");
    req[5] = 1; tick(); expect_port(0, 0, "R8");
    tag = "R9";
    do_eos(); expect_port(1, 5, "R9");
    do_ack(); expect_port(0, 0, "R9");
    do_eos(); expect_port(0, 0, "R9");
    do_eos(); expect_port(1, 2, "R9");
    do_ack(); do_eos(); expect_port(1, 1, "R9");
    do_ack(); do_eos(); expect_port(0, 0, "R9");
    req = '0; tick();

    tag = "R10";
    mask[4] = 1; req[4] = 1; tick(); expect_port(0, 0, "R10");
    mask[6] = 1; req[6] = 1; req[1] = 1; tick(); expect_port(1, 1, "R10");
    mask = '0; tick(); expect_port(1, 6, "R10");
    do_ack(); expect_port(0, 0, "R10");
    do_eos(); expect_port(1, 4, "R10");
    do_ack(); do_eos(); do_ack(); do_eos();
    expect_port(0, 0, "R10");
    req = '0; tick();

    tag = "R11";
    req[3] = 1; tick(); do_ack();
    req[6] = 1; tick(); expect_port(1, 6, "R11");
    ack = 1; eos = 1; tick(); ack = 0; eos = 0;
    expect_port(0, 0, "R11");
    req[2] = 1; tick(); expect_port(0, 0, "R11");
    do_eos(); expect_port(1, 2, "R11");
    do_ack(); do_eos(); expect_port(0, 0, "R11");
    do_eos(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule